// File: doc/BRIEF.md
# UART Modem Control and Status Block

This block keeps the modem-side state of a 16550-style serial port. Software writes a control byte that drives the active-low DTR and RTS output pins, selects diagnostic loopback and holds two enable bits for automatic flow control. A read-only status byte reports the current state of the four active-low modem input lines (CTS, DSR, RI, DCD) and four sticky change flags. Any raised flag, when the modem interrupt enable input is high, raises an interrupt request.

The input lines pass through a two-flop synchronizer before the state register that feeds change detection. In loopback the status lines come from control bits instead of the pins. Setting or clearing those control bits therefore raises change flags, and software can raise modem interrupts without external wiring. Loopback also holds the TXD pin idle high, sends the transmitter's serial stream straight to the receiver and shuts out the RXD pin. The shifters, FIFOs, baud logic and the flow-control machinery that uses the enable bits are outside this block.

Top module: `uart_modem_ctl`

## Requirements
- R1: Control byte layout: bit 0 DTR, bit 1 RTS, bit 2 aux A, bit 3 aux B, bit 4 loopback, bit 5 always reads 0, bit 6 auto-RTS enable, bit 7 auto-CTS enable. Outside loopback a written byte reads back, and dtr_n = ~bit0, rts_n = ~bit1.
- R2: While bit 4 is set, control bits 0 and 1 read as 0.
- R3: While loopback is active, dtr_n and rts_n are both driven high (inactive).
- R4: In loopback txd_pin is 1 and rx_serial_out equals tx_serial_in. Otherwise txd_pin follows tx_serial_in and rx_serial_out follows rx_pin.
- R5: Status bits 7:4 are {~dcd_n, ~ri_n, ~dsr_n, ~cts_n}. A pin change shows three clock edges after it is sampled (two synchronizer stages and one state register).
- R6: In loopback the status CTS line takes control bit 1, DSR takes bit 0, RI takes bit 2 and DCD takes bit 3. The four input pins have no effect.
- R7: Status bits 0, 1 and 3 set on any change of the CTS, DSR and DCD line state respectively.
- R8: Status bit 2 sets only when the RI line state goes from 1 to 0 (the ri_n pin rising). It does not set when the state goes from 0 to 1.
- R9: A status read (reg_rd with reg_sel=1) returns the value from before the read and clears bits 3:0 at that read's clock edge.
- R10: A line event that lands on the same clock edge as a status read leaves its flag set after the read.
- R11: modem_irq is high exactly when msi_en is high and any of status bits 3:0 is set.
- R12: auto_rts_en and auto_cts_en follow control bits 6 and 7.
- R13: After reset the control byte is 0x00, dtr_n and rts_n are high, and with all input pins high the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears flags) |
| reg_sel | input | 1 | 0 selects the control byte, 1 the status byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| msi_en | input | 1 | Modem interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_serial_in | input | 1 | Serial stream from the transmitter |
| rx_pin | input | 1 | RXD pin |
| txd_pin | output | 1 | TXD pin |
| rx_serial_out | output | 1 | Serial stream to the receiver |
| auto_rts_en | output | 1 | Auto-RTS enable bit |
| auto_cts_en | output | 1 | Auto-CTS enable bit |
| modem_irq | output | 1 | Modem status interrupt request |

## Verification
The properties assume the modem pins are high (inactive) while reset is held. They also assume writes to the status select are never issued. The bench drives the pins high during reset and writes only the control byte. Each pin change is held for at least four clocks before the status byte is read, so every observed value comes from a settled synchronizer. The same-edge case of R10 comes from loopback writes, where the clock edge of each line change is known exactly.

// File: rtl/mdm_pkg.sv
// Package: shared widths, line indices and control bit positions of the
// modem control/status block. Assumes four modem lines in the fixed order
// CTS, DSR, RI, DCD, which sets the status bit positions.
package mdm_pkg;
    localparam int MDM_LINES = 4;
    localparam int REG_W     = 8;

    // Line indices; status state bit = index + MDM_LINES, flag bit = index
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // Control byte bit positions
    localparam int CB_DTR   = 0;
    localparam int CB_RTS   = 1;
    localparam int CB_AUXA  = 2;
    localparam int CB_AUXB  = 3;
    localparam int CB_LOOP  = 4;
    localparam int CB_ARTS  = 6;
    localparam int CB_ACTS  = 7;

    // Bit 5 is not stored
    localparam logic [REG_W-1:0] CTL_KEEP_MASK = 8'hDF;

    // Lines whose flag fires only on the state falling from 1 to 0 (RI)
    localparam logic [MDM_LINES-1:0] TRAIL_ONLY = 4'b0100;

    typedef logic [MDM_LINES-1:0] mline_t;
endpackage

// File: rtl/mdm_sync.sv
// Module: multi-stage synchronizer for a bus of independent asynchronous
// bits. Assumes each bit is a level that holds for several clocks; no bus
// coherency is provided. STAGES must be at least 1.
module mdm_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the sampled bus through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_ctl_reg.sv
// Module: control byte storage. Holds DTR/RTS, two auxiliary bits, the
// loopback select and the two flow-control enable bits. Assumes a
// single-cycle write strobe; reading has no side effects.
module mdm_ctl_reg
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic             dtr_bit,
    output logic             rts_bit,
    output logic [1:0]       aux_bits,
    output logic             loop_en,
    output logic             arts_bit,
    output logic             acts_bit,
    output logic [REG_W-1:0] rd_val
);
    logic [REG_W-1:0] ctl_q;

    // Capture written control bits, dropping the unused position
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wdata & CTL_KEEP_MASK;
    end

    assign dtr_bit  = ctl_q[CB_DTR];
    assign rts_bit  = ctl_q[CB_RTS];
    assign aux_bits = {ctl_q[CB_AUXB], ctl_q[CB_AUXA]};
    assign loop_en  = ctl_q[CB_LOOP];
    assign arts_bit = ctl_q[CB_ARTS];
    assign acts_bit = ctl_q[CB_ACTS];

    // Read view: DTR and RTS bits hidden while looping back
    always_comb begin
        rd_val = ctl_q & CTL_KEEP_MASK;
        if (loop_en) begin
            rd_val[CB_DTR] = 1'b0;
            rd_val[CB_RTS] = 1'b0;
        end
    end
endmodule

// File: rtl/mdm_change_det.sv
// Module: line state register and sticky change flags. A line marked in
// TRAIL_MASK raises its flag only when its state falls from 1 to 0; the
// others raise it on any change. Assumes src is already synchronous.
// A clear and a new event on the same edge leave the flag set.
module mdm_change_det #(
    parameter int               LINES      = 4,
    parameter logic [LINES-1:0] TRAIL_MASK = 4'b0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] src,
    input  logic             clr,
    output logic [LINES-1:0] state_q,
    output logic [LINES-1:0] flag_q
);
    logic [LINES-1:0] event_w;

    // Per-line event detector, kind chosen by the mask
    for (genvar i = 0; i < LINES; i++) begin : g_evt
        if (TRAIL_MASK[i]) begin : g_trail
            assign event_w[i] = state_q[i] & ~src[i];
        end else begin : g_any
            assign event_w[i] = state_q[i] ^ src[i];
        end
    end

    // Register the current line state
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= src;
    end

    // Sticky flags: clear on read, new events win over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (clr ? '0 : flag_q) | event_w;
    end
endmodule

// File: rtl/uart_modem_ctl.sv
// Module: modem control and status with diagnostic loopback. Drives the
// DTR/RTS pins from the control byte, reports synchronized modem lines
// and change flags in the status byte, and routes serial data internally
// when loopback is selected. Assumes the modem pins are asynchronous
// levels and that reg_wr is only issued with reg_sel = 0.
module uart_modem_ctl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             msi_en,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             ri_n,
    input  logic             dcd_n,
    output logic             dtr_n,
    output logic             rts_n,
    input  logic             tx_serial_in,
    input  logic             rx_pin,
    output logic             txd_pin,
    output logic             rx_serial_out,
    output logic             auto_rts_en,
    output logic             auto_cts_en,
    output logic             modem_irq
);
    logic       ctl_wr;
    logic       stat_rd;
    logic       dtr_bit;
    logic       rts_bit;
    logic [1:0] aux_bits;
    logic       loop_en;
    logic [REG_W-1:0] ctl_rd;
    mline_t     pin_raw;
    mline_t     pin_sync;
    mline_t     loop_src;
    mline_t     line_src;
    mline_t     line_state;
    mline_t     line_flag;
    logic [REG_W-1:0] status_word;

    assign ctl_wr  = reg_wr & ~reg_sel;
    assign stat_rd = reg_rd & reg_sel;

    mdm_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr),
        .wdata    (reg_wdata),
        .dtr_bit  (dtr_bit),
        .rts_bit  (rts_bit),
        .aux_bits (aux_bits),
        .loop_en  (loop_en),
        .arts_bit (auto_rts_en),
        .acts_bit (auto_cts_en),
        .rd_val   (ctl_rd)
    );

    // Gather the active-low pins in line-index order
    always_comb begin
        pin_raw         = '1;
        pin_raw[LN_CTS] = cts_n;
        pin_raw[LN_DSR] = dsr_n;
        pin_raw[LN_RI]  = ri_n;
        pin_raw[LN_DCD] = dcd_n;
    end

    mdm_sync #(
        .WIDTH   (MDM_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({MDM_LINES{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_sync)
    );

    // Loopback sources: control outputs wired onto the modem inputs
    always_comb begin
        loop_src         = '0;
        loop_src[LN_CTS] = rts_bit;
        loop_src[LN_DSR] = dtr_bit;
        loop_src[LN_RI]  = aux_bits[0];
        loop_src[LN_DCD] = aux_bits[1];
    end

    // Pick the line source: control bits in loopback, pins otherwise
    assign line_src = loop_en ? loop_src : ~pin_sync;

    mdm_change_det #(
        .LINES      (MDM_LINES),
        .TRAIL_MASK (TRAIL_ONLY)
    ) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (line_src),
        .clr     (stat_rd),
        .state_q (line_state),
        .flag_q  (line_flag)
    );

    assign status_word = {line_state, line_flag};

    // Read data mux
    assign reg_rdata = reg_sel ? status_word : ctl_rd;

    // Modem output pins, parked inactive in loopback
    assign dtr_n = loop_en ? 1'b1 : ~dtr_bit;
    assign rts_n = loop_en ? 1'b1 : ~rts_bit;

    // Serial routing: internal loop or pass-through
    assign txd_pin       = loop_en ? 1'b1 : tx_serial_in;
    assign rx_serial_out = loop_en ? tx_serial_in : rx_pin;

    // Interrupt request from any raised flag
    assign modem_irq = msi_en & (|line_flag);
endmodule

// File: rtl/mdm_chk.sv
// Module: property checker for uart_modem_ctl, attached by bind below.
// Assumes modem pins are high during reset.
module mdm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_en,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       txd_pin,
    input logic       rx_serial_out,
    input logic       tx_serial_in,
    input logic [7:0] status_word,
    input logic       stat_rd,
    input logic       msi_en,
    input logic       modem_irq
);
    // R3
    loop_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (dtr_n && rts_n));

    // R4
    loop_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (txd_pin && (rx_serial_out == tx_serial_in)));

    // R7
    cts_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_word[4]) |-> status_word[0]);

    // R7
    dsr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_word[5]) |-> status_word[1]);

    // R7
    dcd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_word[7]) |-> status_word[3]);

    // R8
    ring_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_word[6]) |-> status_word[2]);

    // R8
    ring_lead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status_word[6]) && !$past(status_word[2])) |-> !status_word[2]);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (!$stable(status_word[7:4]) || (status_word[3:0] == 4'b0000)));

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |-> !modem_irq);
endmodule

bind uart_modem_ctl mdm_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .loop_en       (loop_en),
    .dtr_n         (dtr_n),
    .rts_n         (rts_n),
    .txd_pin       (txd_pin),
    .rx_serial_out (rx_serial_out),
    .tx_serial_in  (tx_serial_in),
    .status_word   (status_word),
    .stat_rd       (stat_rd),
    .msi_en        (msi_en),
    .modem_irq     (modem_irq)
);

// File: tb/uart_modem_ctl_tb.sv
// Bench: scoreboard. Driver tasks queue expected bytes; a monitor pops
// and compares them at the falling edge of the cycle they belong to.
module uart_modem_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       msi_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       dsr_n = 1'b1;
    logic       ri_n = 1'b1;
    logic       dcd_n = 1'b1;
    logic       dtr_n;
    logic       rts_n;
    logic       tx_serial_in = 1'b0;
    logic       rx_pin = 1'b1;
    logic       txd_pin;
    logic       rx_serial_out;
    logic       auto_rts_en;
    logic       auto_cts_en;
    logic       modem_irq;

    typedef struct {
        string      tag;
        logic [7:0] exp;
        bit         from_pins;
    } exp_t;

    exp_t sb_q[$];
    logic mon_req = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_modem_ctl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .msi_en        (msi_en),
        .cts_n         (cts_n),
        .dsr_n         (dsr_n),
        .ri_n          (ri_n),
        .dcd_n         (dcd_n),
        .dtr_n         (dtr_n),
        .rts_n         (rts_n),
        .tx_serial_in  (tx_serial_in),
        .rx_pin        (rx_pin),
        .txd_pin       (txd_pin),
        .rx_serial_out (rx_serial_out),
        .auto_rts_en   (auto_rts_en),
        .auto_cts_en   (auto_cts_en),
        .modem_irq     (modem_irq)
    );

    // Pin probe: {irq, dtr_n, rts_n, txd, rx_out, auto_rts, auto_cts, 0}
    wire [7:0] pin_vec = {modem_irq, dtr_n, rts_n, txd_pin, rx_serial_out,
                          auto_rts_en, auto_cts_en, 1'b0};

    // Monitor: compare one queued item per requested cycle
    always @(negedge clk) begin
        if (mon_req) begin
            exp_t it;
            logic [7:0] act;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual=%02h expected=none", reg_rdata);
            end else begin
                it  = sb_q.pop_front();
                act = it.from_pins ? pin_vec : reg_rdata;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Tasks assume entry just after a rising edge and leave just after one
    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = v;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic sel, input logic [7:0] exp, input string tag);
        exp_t it;
        it.tag = tag; it.exp = exp; it.from_pins = 1'b0;
        sb_q.push_back(it);
        reg_rd = 1'b1; reg_sel = sel; mon_req = 1'b1;
        step(1);
        reg_rd = 1'b0; reg_sel = 1'b0; mon_req = 1'b0;
    endtask

    task automatic pin_chk(input logic [7:0] exp, input string tag);
        exp_t it;
        it.tag = tag; it.exp = exp; it.from_pins = 1'b1;
        sb_q.push_back(it);
        mon_req = 1'b1;
        step(1);
        mon_req = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    // Stimulus
    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R13 reset state
        rd_chk(1'b0, 8'h00, "R13 ctl reset");
        rd_chk(1'b1, 8'h00, "R13 status reset");
        pin_chk(8'h68, "R13 pins reset");

        // R1 R12 control byte and DTR/RTS pins
        wr_ctl(8'hC3);
        rd_chk(1'b0, 8'hC3, "R1 ctl readback");
        pin_chk(8'h0E, "R12 R1 pins dtr/rts low, auto on");
        wr_ctl(8'hE1);
        rd_chk(1'b0, 8'hC1, "R1 bit5 reads 0");
        pin_chk(8'h2E, "R1 rts released");

        // R5 R7 R9 R11 CTS change
        msi_en = 1'b1;
        cts_n = 1'b0;
        step(4);
        pin_chk(8'hAE, "R11 irq on cts flag");
        rd_chk(1'b1, 8'h11, "R5 R7 cts state and flag");
        rd_chk(1'b1, 8'h10, "R9 flag cleared by read");
        pin_chk(8'h2E, "R11 irq drops");

        // R7 DSR and DCD together
        dsr_n = 1'b0; dcd_n = 1'b0;
        step(4);
        rd_chk(1'b1, 8'hBA, "R7 dsr dcd flags");
        rd_chk(1'b1, 8'hB0, "R9 cleared");

        // R8 ring edges
        ri_n = 1'b0;
        step(4);
        rd_chk(1'b1, 8'hF0, "R8 ring start no flag");
        ri_n = 1'b1;
        step(4);
        rd_chk(1'b1, 8'hB4, "R8 ring end flag");
        rd_chk(1'b1, 8'hB0, "R9 ring flag cleared");

        // R11 gate
        msi_en = 1'b0;
        cts_n = 1'b1;
        step(4);
        pin_chk(8'h2E, "R11 irq gated off");
        msi_en = 1'b1;
        step(1);
        pin_chk(8'hAE, "R11 irq enabled");
        rd_chk(1'b1, 8'hA1, "R7 cts fall flag");

        // R4 pass-through
        tx_serial_in = 1'b1; rx_pin = 1'b0;
        step(1);
        pin_chk(8'h36, "R4 normal routing");

        // Loopback entry
        wr_ctl(8'h1B);
        rd_chk(1'b0, 8'h18, "R2 dtr/rts read 0 in loop");
        pin_chk(8'hF8, "R3 R4 loop pins");
        tx_serial_in = 1'b0;
        step(1);
        pin_chk(8'hF0, "R4 loop data to receiver");
        // R6 pins ignored in loop
        dcd_n = 1'b1; ri_n = 1'b0; cts_n = 1'b0;
        step(4);
        rd_chk(1'b1, 8'hB1, "R6 loop sources");

        // R8 via control bit 2
        wr_ctl(8'h1F);
        step(2);
        rd_chk(1'b1, 8'hF0, "R8 loop ring start");
        wr_ctl(8'h1B);
        step(2);
        rd_chk(1'b1, 8'hB4, "R8 loop ring end");
        rd_chk(1'b1, 8'hB0, "R9 loop cleared");

        // R10 event on the read edge
        wr_ctl(8'h1A);
        rd_chk(1'b1, 8'hB0, "R10 read on event edge");
        rd_chk(1'b1, 8'h92, "R10 flag survives read");

        // Loopback exit
        wr_ctl(8'h03);
        step(2);
        rd_chk(1'b1, 8'h7A, "R6 pins back after loop");
        rx_pin = 1'b0;
        pin_chk(8'h00, "R3 R4 loop released");

        if (sb_q.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule